// File: doc/BRIEF.md
# Bus Halt Output Controller

This block sits between a processor's bus sequencer and its pin drivers and decides what every bus output does when an external agent asks the processor to stop. A stop request is honoured only at the boundary of a bus cycle. Once stopped, the outputs fall into three groups. The data bus is released to high impedance. The address strobe and data strobe stay driven, but at their inactive level. Address, function code, transfer size and read/write keep showing the values of the cycle that just finished.

Bus arbitration keeps working while the processor is stopped. If another master takes the bus, every address-type and control output goes to high impedance. When the bus comes back and the stop request is still present, the captured address-type values are driven again. Interrupts are not taken while stopped, but the pending indication keeps following its source. Releasing the stop request lets new cycles start on the next clock, provided the block owns the bus at that moment.

Top module: `bus_halt_ctl`

## Requirements
- R1: The block enters the stopped state (`halted`=1) only on a clock edge where `cyc_done`=1, `halt_req`=1 and `bus_mine`=1. Holding `halt_req` high without `cyc_done` leaves `halted` at 0.
- R2: While stopped, `data_oe` is 0 whatever `data_drive` is.
- R3: While stopped and owning the bus, `ctl_oe` is 1 and the active-low strobes `as_n`/`ds_n` are 1, even when `as_req`/`ds_req` are 1.
- R4: While stopped, `addr_out`, `fc_out`, `siz_out` and `rw_out` show the values that `addr_in`, `fc_in`, `siz_in` and `rw_in` had on the edge that finished the last cycle. Later changes on those inputs have no effect.
- R5: Whenever `bus_mine`=0, `addr_oe`, `ctl_oe` and `data_oe` are all 0.
- R6: When `bus_mine` returns to 1 while stopped, `addr_oe` becomes 1 and the address-type outputs again show the captured values. Captured values survive the period without the bus.
- R7: While stopped, `irq_take` is 0. `ipend_out` follows `irq_pend_in` at all times.
- R8: If `halt_req` is 0 and `bus_mine` is 1 while stopped, `halted` clears on the next clock. After that, the strobes follow `as_req`/`ds_req` and the address-type outputs follow their live inputs.
- R9: Synchronous reset `rst`=1 holds `as_n`=`ds_n`=1 and clears `halted` on the next clock.
- R10: If `halt_req` falls while `bus_mine`=0, the block stays stopped until the bus returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_req | input | 1 | External stop request |
| cyc_done | input | 1 | Current bus cycle finishes on this edge |
| bus_mine | input | 1 | 1 when this processor owns the bus |
| addr_in | input | AW | Address from sequencer |
| fc_in | input | FCW | Function code from sequencer |
| siz_in | input | SZW | Transfer size from sequencer |
| rw_in | input | 1 | Read/write from sequencer |
| data_in | input | DW | Write data from sequencer |
| data_drive | input | 1 | Sequencer wants to drive data |
| as_req | input | 1 | Sequencer asserts address strobe |
| ds_req | input | 1 | Sequencer asserts data strobe |
| irq_pend_in | input | 1 | Interrupt pending from priority logic |
| halted | output | 1 | Stopped state |
| addr_out | output | AW | Address pin value |
| fc_out | output | FCW | Function code pin value |
| siz_out | output | SZW | Size pin value |
| rw_out | output | 1 | Read/write pin value |
| addr_oe | output | 1 | Enable for address, function code, size, read/write |
| data_out | output | DW | Data pin value |
| data_oe | output | 1 | Data driver enable |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| ctl_oe | output | 1 | Strobe driver enable |
| irq_take | output | 1 | Interrupt may be serviced |
| ipend_out | output | 1 | Interrupt pending indication |

## Verification
The two events that can land on the same edge are the release of the stop request and the return of bus ownership. The bench drops `halt_req` while the bus is away and confirms that the block stays stopped. It then raises `bus_mine` and checks that in the cycle of return the captured address is driven with the strobes still inactive, and that on the next edge the block is running on live values. Entry into the stopped state is also checked with stale inputs changed right after the finishing edge, so that a capture on the wrong edge would show up as a mismatch.

// File: rtl/bus_halt_ctl.sv
module bus_halt_ctl #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int FCW = 3,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           halt_req,
  input  logic           cyc_done,
  input  logic           bus_mine,
  input  logic [AW-1:0]  addr_in,
  input  logic [FCW-1:0] fc_in,
  input  logic [SZW-1:0] siz_in,
  input  logic           rw_in,
  input  logic [DW-1:0]  data_in,
  input  logic           data_drive,
  input  logic           as_req,
  input  logic           ds_req,
  input  logic           irq_pend_in,
  output logic           halted,
  output logic [AW-1:0]  addr_out,
  output logic [FCW-1:0] fc_out,
  output logic [SZW-1:0] siz_out,
  output logic           rw_out,
  output logic           addr_oe,
  output logic [DW-1:0]  data_out,
  output logic           data_oe,
  output logic           as_n,
  output logic           ds_n,
  output logic           ctl_oe,
  output logic           irq_take,
  output logic           ipend_out
);

  logic [AW-1:0]  hold_addr;
  logic [FCW-1:0] hold_fc;
  logic [SZW-1:0] hold_siz;
  logic           hold_rw;

  wire freeze  = !halted && bus_mine && cyc_done && halt_req;
  wire thaw    = halted && bus_mine && !halt_req;
  wire running = bus_mine && !halted && !rst;

  always_ff @(posedge clk) begin
    if (rst)         halted <= 1'b0;
    else if (freeze) halted <= 1'b1;
    else if (thaw)   halted <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr <= '0;
      hold_fc   <= '0;
      hold_siz  <= '0;
      hold_rw   <= 1'b1;
    end else if (freeze) begin
      hold_addr <= addr_in;
      hold_fc   <= fc_in;
      hold_siz  <= siz_in;
      hold_rw   <= rw_in;
    end
  end

  assign addr_out  = halted ? hold_addr : addr_in;
  assign fc_out    = halted ? hold_fc   : fc_in;
  assign siz_out   = halted ? hold_siz  : siz_in;
  assign rw_out    = halted ? hold_rw   : rw_in;
  assign addr_oe   = bus_mine;

  assign data_out  = data_in;
  assign data_oe   = running && data_drive;

  assign ctl_oe    = bus_mine;
  assign as_n      = !(running && as_req);
  assign ds_n      = !(running && ds_req);

  assign irq_take  = irq_pend_in && !halted;
  assign ipend_out = irq_pend_in;

  a_r1_entry_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(cyc_done && halt_req && bus_mine));
  a_r2_data_hiz: assert property (@(posedge clk) disable iff (rst)
    halted |-> !data_oe);
  a_r3_strobes_idle: assert property (@(posedge clk) disable iff (rst)
    (halted && bus_mine) |-> (ctl_oe && as_n && ds_n));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (halted && $past(halted)) |-> ($stable(addr_out) && $stable(fc_out) && $stable(siz_out) && $stable(rw_out)));
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    !bus_mine |-> (!addr_oe && !ctl_oe && !data_oe));
  a_r7_no_irq: assert property (@(posedge clk) disable iff (rst)
    halted |-> !irq_take);
  a_r8_exit: assert property (@(posedge clk) disable iff (rst)
    (halted && bus_mine && !halt_req) |=> !halted);
  a_r9_reset: assert property (@(posedge clk)
    rst |=> !halted);
  a_r10_stay: assert property (@(posedge clk) disable iff (rst)
    (halted && !bus_mine) |=> halted);

endmodule

// File: tb/sim_bus_halt_ctl.sv
module sim_bus_halt_ctl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, halt_req, cyc_done, bus_mine, rw_in, data_drive, as_req, ds_req, irq_pend_in;
  logic [31:0] addr_in, data_in;
  logic [2:0]  fc_in;
  logic [1:0]  siz_in;
  logic halted, rw_out, addr_oe, data_oe, as_n, ds_n, ctl_oe, irq_take, ipend_out;
  logic [31:0] addr_out, data_out;
  logic [2:0]  fc_out;
  logic [1:0]  siz_out;

  int checks = 0;
  int errors = 0;

  bus_halt_ctl u0 (
    .clk(clk), .rst(rst), .halt_req(halt_req), .cyc_done(cyc_done), .bus_mine(bus_mine),
    .addr_in(addr_in), .fc_in(fc_in), .siz_in(siz_in), .rw_in(rw_in), .data_in(data_in),
    .data_drive(data_drive), .as_req(as_req), .ds_req(ds_req), .irq_pend_in(irq_pend_in),
    .halted(halted), .addr_out(addr_out), .fc_out(fc_out), .siz_out(siz_out), .rw_out(rw_out),
    .addr_oe(addr_oe), .data_out(data_out), .data_oe(data_oe), .as_n(as_n), .ds_n(ds_n),
    .ctl_oe(ctl_oe), .irq_take(irq_take), .ipend_out(ipend_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1; halt_req = 0; cyc_done = 0; bus_mine = 1; as_req = 1; ds_req = 1;
    data_drive = 0; irq_pend_in = 0; addr_in = 32'h100; fc_in = 3'd1; siz_in = 2'd0;
    rw_in = 1; data_in = 32'h0;
    #1;
    chk("R9 as_n in reset", as_n, 1);
    chk("R9 ds_n in reset", ds_n, 1);
    tick(2);
    chk("R9 halted after reset", halted, 0);
    rst = 0;
    #1;
    chk("R8 strobe live after reset", as_n, 0);
  endtask

  task automatic t_no_entry;
    halt_req = 1; cyc_done = 0;
    tick(3);
    chk("R1 no entry without cycle end", halted, 0);
  endtask

  task automatic t_entry;
    addr_in = 32'hCAFE_0010; fc_in = 3'd5; siz_in = 2'd2; rw_in = 0; cyc_done = 1; halt_req = 1;
    tick(1);
    cyc_done = 0; addr_in = 32'h1234_5678; fc_in = 3'd2; siz_in = 2'd1; rw_in = 1;
    data_drive = 1; as_req = 1; ds_req = 1; irq_pend_in = 1;
    #1;
    chk("R1 entered", halted, 1);
    chk("R4 addr held", addr_out, 32'hCAFE_0010);
    chk("R4 fc held", fc_out, 5);
    chk("R4 siz held", siz_out, 2);
    chk("R4 rw held", rw_out, 0);
    chk("R2 data hiz", data_oe, 0);
    chk("R3 ctl_oe", ctl_oe, 1);
    chk("R3 as_n idle", as_n, 1);
    chk("R3 ds_n idle", ds_n, 1);
    chk("R7 irq blocked", irq_take, 0);
    chk("R7 ipend follows", ipend_out, 1);
    irq_pend_in = 0; #1;
    chk("R7 ipend follows low", ipend_out, 0);
    cyc_done = 1; addr_in = 32'h9; tick(2); cyc_done = 0;
    chk("R4 no recapture", addr_out, 32'hCAFE_0010);
  endtask

  task automatic t_arb_release_away;
    bus_mine = 0; #1;
    chk("R5 addr_oe off", addr_oe, 0);
    chk("R5 ctl_oe off", ctl_oe, 0);
    chk("R5 data_oe off", data_oe, 0);
    tick(2);
    halt_req = 0;
    tick(3);
    chk("R10 still halted while away", halted, 1);
    bus_mine = 1; addr_in = 32'h0000_BEEF; #1;
    chk("R6 addr_oe back", addr_oe, 1);
    chk("R6 addr restored", addr_out, 32'hCAFE_0010);
    chk("R3 strobes idle on return", as_n, 1);
    tick(1);
    chk("R8 exit next clock", halted, 0);
    chk("R8 live addr", addr_out, 32'h0000_BEEF);
    chk("R8 strobes live", as_n, 0);
    chk("R8 data live", data_oe, 1);
  endtask

  task automatic t_arb_return_still_halted;
    addr_in = 32'hA5A5_0004; halt_req = 1; cyc_done = 1;
    tick(1); cyc_done = 0; addr_in = 32'h1;
    bus_mine = 0; tick(3);
    bus_mine = 1; #1;
    chk("R6 restored while halt held", addr_out, 32'hA5A5_0004);
    tick(2);
    chk("R6 still halted", halted, 1);
  endtask

  task automatic t_reset_in_halt;
    rst = 1; tick(1); rst = 0; halt_req = 0; #1;
    chk("R9 reset clears halt", halted, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_no_entry;
    t_entry;
    t_arb_release_away;
    t_arb_return_still_halted;
    t_reset_in_halt;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule